// File: doc/BRIEF.md
# Dual-Port Parity-Protected RAM with Selectable Write-Through

The block is a synchronous RAM with two ports, A and B, each with its own enable, write strobe, address and write data. In the default true dual-port build either port may read or write on any clock edge. A build-time mode for each port decides what that port's read output shows on a cycle in which it writes. The options are the incoming data, the word that was just overwritten, or the previous read result left in place.

Each data byte is stored with one even-parity bit, so a 32-bit word occupies 36 bits. On every read the stored parity is compared against parity recomputed from the stored data. A per-byte inversion mask on each write port deliberately corrupts stored parity, which lets the error output be exercised. An optional output register adds one cycle of read latency. A simple dual-port build turns port A into a write-only port and port B into a read-only port. When both ports write one address on the same edge, the location's contents become undefined and a one-cycle flag is raised.

Top module: `dpram_bytepar`

## Requirements
- R1: While rst_ni is low and after its release, both read outputs, both parity-error outputs and collision_o are 0 until the first access.
- R2: A read, meaning en high and we low, returns the addressed word one clock edge later with OUT_REG=0, and two edges later with OUT_REG=1.
- R3: In write-first mode, a write makes the port's read output show the written data.
- R4: In read-first mode, a write makes the port's read output show the contents that the location held before the write.
- R5: In no-change mode, a write leaves the port's read output at its previous value.
- R6: When one port reads an address on the same edge that the other port writes it, the reading port returns the old contents.
- R7: Byte k of a word is data bits [8k+7:8k]. Its stored parity bit is the XOR of those 8 bits. A word written with a zero inversion mask reads back with the parity-error output low.
- R8: Bit k of a port's parity-inversion mask inverts the stored parity bit of byte k. A later read of that word raises the parity-error output, and so does a write-first write of it.
- R9: collision_o is high for exactly the one cycle after an edge on which both ports write the same address. It stays low when the two write addresses differ.
- R10: With SDP=1, port A reads have no effect and a_rdata_o and a_perr_o stay 0. Port B's write strobe is ignored, so B always reads. collision_o stays 0.
- R11: A port whose enable is low neither writes nor changes its read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all accesses on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the output state |
| a_en_i | input | 1 | Port A access enable |
| a_we_i | input | 1 | Port A write strobe |
| a_addr_i | input | ADDR_W | Port A word address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_pinv_i | input | DATA_W/8 | Port A per-byte parity inversion mask |
| a_rdata_o | output | DATA_W | Port A read data |
| a_perr_o | output | 1 | Port A parity error on the shown word |
| b_en_i | input | 1 | Port B access enable |
| b_we_i | input | 1 | Port B write strobe |
| b_addr_i | input | ADDR_W | Port B word address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_pinv_i | input | DATA_W/8 | Port B per-byte parity inversion mask |
| b_rdata_o | output | DATA_W | Port B read data |
| b_perr_o | output | 1 | Port B parity error on the shown word |
| collision_o | output | 1 | Same-address write/write on the previous edge |

## Verification
The bench drives three instances from one shared stimulus, all with DATA_W=32 and ADDR_W=4 so that random addresses overlap often. The first instance uses write-first on A, read-first on B and no output register. The second uses no-change on both ports with OUT_REG=1, which brings the hold behaviour and the extra pipeline cycle within reach. The third is built with SDP=1, which exposes the ignored port-A reads and port-B writes. The shallow depth makes cross-port same-address reads and deliberate write/write collisions easy to reach. Random runs also inject parity corruption.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;
endpackage

// File: rtl/dpr_par_gen.sv
module dpr_par_gen import dpr_pkg::*; #(
  parameter int unsigned NBYTE = 4
) (
  input  logic [NBYTE*BYTE_W-1:0] data_i,
  output logic [NBYTE-1:0]        par_o
);
  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    assign par_o[k] = ^data_i[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out import dpr_pkg::*; #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NBYTE   = DATA_W / BYTE_W,
  parameter int unsigned STORE_W = DATA_W + NBYTE,
  parameter wmode_e      WMODE   = WM_READ_FIRST,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic               wr_i,
  input  logic [STORE_W-1:0] old_i,
  input  logic [STORE_W-1:0] new_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               perr_o
);
  logic [STORE_W-1:0] lat_q, nxt, out_w;
  logic               load;
  logic [NBYTE-1:0]   par_calc;

  // stored layout: {parity[NBYTE-1:0], data[DATA_W-1:0]}
  assign load = acc_i && !(wr_i && WMODE == WM_NO_CHANGE);
  assign nxt  = (wr_i && WMODE == WM_WRITE_FIRST) ? new_i : old_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lat_q <= '0;
    else if (load) lat_q <= nxt;
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_w <= '0;
      else         out_w <= lat_q;
    end
    p_out_pipe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> out_w == $past(lat_q));
  end else begin : g_noreg
    assign out_w = lat_q;
  end

  dpr_par_gen #(.NBYTE(NBYTE)) u_chk (
    .data_i(out_w[DATA_W-1:0]),
    .par_o (par_calc)
  );

  assign rdata_o = out_w[DATA_W-1:0];
  assign perr_o  = |(par_calc ^ out_w[STORE_W-1:DATA_W]);

  if (WMODE == WM_WRITE_FIRST) begin : g_a_wf
    p_write_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_i && wr_i |=> lat_q == $past(new_i));
  end else if (WMODE == WM_READ_FIRST) begin : g_a_rf
    p_read_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_i && wr_i |=> lat_q == $past(old_i));
  end else begin : g_a_nc
    p_no_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_i && wr_i |=> $stable(lat_q));
  end

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(lat_q));
endmodule

// File: rtl/dpram_bytepar.sv
module dpram_bytepar import dpr_pkg::*; #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6,
  parameter wmode_e      WMODE_A = WM_WRITE_FIRST,
  parameter wmode_e      WMODE_B = WM_READ_FIRST,
  parameter bit          OUT_REG = 1'b0,
  parameter bit          SDP     = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     a_en_i,
  input  logic                     a_we_i,
  input  logic [ADDR_W-1:0]        a_addr_i,
  input  logic [DATA_W-1:0]        a_wdata_i,
  input  logic [DATA_W/BYTE_W-1:0] a_pinv_i,
  output logic [DATA_W-1:0]        a_rdata_o,
  output logic                     a_perr_o,
  input  logic                     b_en_i,
  input  logic                     b_we_i,
  input  logic [ADDR_W-1:0]        b_addr_i,
  input  logic [DATA_W-1:0]        b_wdata_i,
  input  logic [DATA_W/BYTE_W-1:0] b_pinv_i,
  output logic [DATA_W-1:0]        b_rdata_o,
  output logic                     b_perr_o,
  output logic                     collision_o
);
  localparam int unsigned NBYTE   = DATA_W / BYTE_W;
  localparam int unsigned STORE_W = DATA_W + NBYTE;
  localparam int unsigned DEPTH   = 1 << ADDR_W;

  logic [STORE_W-1:0] mem [DEPTH];
  logic [NBYTE-1:0]   par_a, par_b;
  logic [STORE_W-1:0] enc_a, enc_b, old_a, old_b;
  logic               wr_a, wr_b, acc_a, collide, collision_q;

  dpr_par_gen #(.NBYTE(NBYTE)) u_par_a (.data_i(a_wdata_i), .par_o(par_a));
  dpr_par_gen #(.NBYTE(NBYTE)) u_par_b (.data_i(b_wdata_i), .par_o(par_b));

  assign enc_a   = {par_a ^ a_pinv_i, a_wdata_i};
  assign enc_b   = {par_b ^ b_pinv_i, b_wdata_i};
  assign wr_a    = a_en_i && a_we_i;
  assign wr_b    = b_en_i && b_we_i && !SDP;
  assign acc_a   = a_en_i && !SDP;
  assign collide = wr_a && wr_b && (a_addr_i == b_addr_i);
  assign old_a   = mem[a_addr_i];
  assign old_b   = mem[b_addr_i];

  // same-address write/write leaves the word undefined
  always_ff @(posedge clk_i) begin
    if (wr_a)             mem[a_addr_i] <= collide ? {STORE_W{1'bx}} : enc_a;
    if (wr_b && !collide) mem[b_addr_i] <= enc_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) collision_q <= 1'b0;
    else         collision_q <= collide;
  end
  assign collision_o = collision_q;

  dpr_port_out #(
    .DATA_W(DATA_W), .NBYTE(NBYTE), .STORE_W(STORE_W),
    .WMODE(WMODE_A), .OUT_REG(OUT_REG)
  ) u_out_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_a), .wr_i(wr_a),
    .old_i(old_a), .new_i(enc_a), .rdata_o(a_rdata_o), .perr_o(a_perr_o)
  );

  dpr_port_out #(
    .DATA_W(DATA_W), .NBYTE(NBYTE), .STORE_W(STORE_W),
    .WMODE(WMODE_B), .OUT_REG(OUT_REG)
  ) u_out_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(b_en_i), .wr_i(wr_b),
    .old_i(old_b), .new_i(enc_b), .rdata_o(b_rdata_o), .perr_o(b_perr_o)
  );

  p_collision_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_en_i && a_we_i && b_en_i && b_we_i && (a_addr_i == b_addr_i) && !SDP
    |=> collision_o);
  p_collision_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_en_i && a_we_i && b_en_i && b_we_i && (a_addr_i == b_addr_i))
    |=> !collision_o);

  if (SDP) begin : g_sdp_chk
    p_sdp_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_rdata_o == '0 && !a_perr_o && !collision_o);
  end
endmodule

// File: tb/dpram_bytepar_bench.sv
module dpram_bytepar_bench;
  import dpr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NB = DW / 8;
  localparam int SW = DW + NB;
  localparam int DEP = 1 << AW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_ad, b_ad;
  logic [DW-1:0] a_wd, b_wd;
  logic [NB-1:0] a_pi, b_pi;

  logic [DW-1:0] r0a, r0b, r1a, r1b, rsa, rsb;
  logic p0a, p0b, p1a, p1b, psa, psb, c0, c1, cs;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dpram_bytepar #(.DATA_W(DW), .ADDR_W(AW), .WMODE_A(WM_WRITE_FIRST),
    .WMODE_B(WM_READ_FIRST), .OUT_REG(1'b0), .SDP(1'b0)) u_dpram_bytepar (
    .clk_i, .rst_ni, .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_ad), .a_wdata_i(a_wd),
    .a_pinv_i(a_pi), .a_rdata_o(r0a), .a_perr_o(p0a), .b_en_i(b_en), .b_we_i(b_we),
    .b_addr_i(b_ad), .b_wdata_i(b_wd), .b_pinv_i(b_pi), .b_rdata_o(r0b), .b_perr_o(p0b),
    .collision_o(c0));

  dpram_bytepar #(.DATA_W(DW), .ADDR_W(AW), .WMODE_A(WM_NO_CHANGE),
    .WMODE_B(WM_NO_CHANGE), .OUT_REG(1'b1), .SDP(1'b0)) u_dpram_bytepar_pipe (
    .clk_i, .rst_ni, .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_ad), .a_wdata_i(a_wd),
    .a_pinv_i(a_pi), .a_rdata_o(r1a), .a_perr_o(p1a), .b_en_i(b_en), .b_we_i(b_we),
    .b_addr_i(b_ad), .b_wdata_i(b_wd), .b_pinv_i(b_pi), .b_rdata_o(r1b), .b_perr_o(p1b),
    .collision_o(c1));

  dpram_bytepar #(.DATA_W(DW), .ADDR_W(AW), .WMODE_A(WM_WRITE_FIRST),
    .WMODE_B(WM_READ_FIRST), .OUT_REG(1'b0), .SDP(1'b1)) u_dpram_bytepar_sdp (
    .clk_i, .rst_ni, .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_ad), .a_wdata_i(a_wd),
    .a_pinv_i(a_pi), .a_rdata_o(rsa), .a_perr_o(psa), .b_en_i(b_en), .b_we_i(b_we),
    .b_addr_i(b_ad), .b_wdata_i(b_wd), .b_pinv_i(b_pi), .b_rdata_o(rsb), .b_perr_o(psb),
    .collision_o(cs));

  // model words hold {inversion mask, data}; parity error == any mask bit set
  logic [SW-1:0] mw [DEP];
  logic [SW-1:0] sw [DEP];
  logic [SW-1:0] lat0a = '0, lat0b = '0, lat1a = '0, lat1b = '0;
  logic [SW-1:0] out1a = '0, out1b = '0, latsb = '0;
  logic          col_exp = 1'b0;

  function automatic logic [SW-1:0] nxt(input int mode, input logic en, input logic we,
                                        input logic [SW-1:0] old, input logic [SW-1:0] nw,
                                        input logic [SW-1:0] cur);
    if (!en) return cur;
    if (!we) return old;
    if (mode == 0) return nw;
    if (mode == 1) return old;
    return cur;
  endfunction

  function automatic logic [DW:0] shown(input logic [SW-1:0] w);
    return {|w[SW-1:DW], w[DW-1:0]};
  endfunction

  task automatic chk(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [SW-1:0] wa, wb, oa, ob, sob, n0a, n0b, n1a, n1b, o1a, o1b, nsb;
    logic col;
    wa  = {a_pi, a_wd};
    wb  = {b_pi, b_wd};
    oa  = mw[a_ad];
    ob  = mw[b_ad];
    sob = sw[b_ad];
    n0a = nxt(0, a_en, a_we, oa, wa, lat0a);
    n0b = nxt(1, b_en, b_we, ob, wb, lat0b);
    n1a = nxt(2, a_en, a_we, oa, wa, lat1a);
    n1b = nxt(2, b_en, b_we, ob, wb, lat1b);
    o1a = lat1a;
    o1b = lat1b;
    nsb = b_en ? sob : latsb;
    col = a_en && a_we && b_en && b_we && (a_ad == b_ad);
    if (a_en && a_we) begin mw[a_ad] = wa; sw[a_ad] = wa; end
    if (b_en && b_we && !col) mw[b_ad] = wb;
    @(posedge clk_i);
    #1;
    lat0a = n0a; lat0b = n0b; lat1a = n1a; lat1b = n1b;
    out1a = o1a; out1b = o1b; latsb = nsb; col_exp = col;
    chk({tag, " port A"}, {p0a, r0a}, shown(lat0a));
    chk({tag, " port B"}, {p0b, r0b}, shown(lat0b));
    chk({tag, " pipe A"}, {p1a, r1a}, shown(out1a));
    chk({tag, " pipe B"}, {p1b, r1b}, shown(out1b));
    chk({tag, " R10 sdp A"}, {psa, rsa}, '0);
    chk({tag, " sdp B"}, {psb, rsb}, shown(latsb));
    chk({tag, " R9 collision"}, {32'b0, c0}, {32'b0, col_exp});
    chk({tag, " R9 collision pipe"}, {32'b0, c1}, {32'b0, col_exp});
    chk({tag, " R10 collision sdp"}, {32'b0, cs}, '0);
  endtask

  task automatic idle();
    a_en = 0; a_we = 0; b_en = 0; b_we = 0; a_pi = '0; b_pi = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle();
    a_ad = '0; b_ad = '0; a_wd = '0; b_wd = '0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    chk("R1 A", {p0a, r0a}, '0);
    chk("R1 B", {p0b, r0b}, '0);
    chk("R1 pipe", {p1b, r1b}, '0);
    chk("R1 collision", {32'b0, c0}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R1 after release", {p0a, r0a}, '0);

    // fill through port A (R3 write-first on A, R7 clean parity)
    for (int i = 0; i < DEP; i++) begin
      idle(); a_en = 1; a_we = 1; a_ad = AW'(i); a_wd = $urandom;
      step("R3 R7 fill");
    end
    // R2: plain reads on both ports, then a bubble for the pipe
    idle(); a_en = 1; a_ad = 4'd1; b_en = 1; b_ad = 4'd2; step("R2 read");
    idle(); step("R2 R11 idle");
    // R4/R5: port B write, read-first vs no-change
    idle(); b_en = 1; b_we = 1; b_ad = 4'd3; b_wd = 32'hA5A5_0F0F; step("R4 R5 write B");
    idle(); b_en = 1; b_ad = 4'd3; step("R2 read back B");
    // R6: cross-port read of an address being written
    idle(); a_en = 1; a_we = 1; a_ad = 4'd5; a_wd = 32'h1234_5678;
    b_en = 1; b_ad = 4'd5; step("R6 cross read");
    idle(); b_en = 1; b_ad = 4'd5; step("R6 new value");
    // R8: corrupted parity on byte 2
    idle(); a_en = 1; a_we = 1; a_ad = 4'd7; a_wd = 32'hFFFF_0001; a_pi = 4'b0100;
    step("R8 inject");
    idle(); b_en = 1; b_ad = 4'd7; step("R8 read bad");
    // R9: write/write collision, then repair the location
    idle(); a_en = 1; a_we = 1; b_en = 1; b_we = 1; a_ad = 4'd9; b_ad = 4'd9;
    a_wd = 32'h0BAD_CAFE; b_wd = 32'hDEAD_BEEF; step("R9 collide");
    idle(); a_en = 1; a_we = 1; a_ad = 4'd9; a_wd = 32'h0000_0099; step("R9 single cycle");
    // R9: different addresses do not collide
    idle(); a_en = 1; a_we = 1; b_en = 1; b_we = 1; a_ad = 4'd10; b_ad = 4'd11;
    a_wd = $urandom; b_wd = $urandom; step("R9 distinct");
    // R11: disabled ports with live strobes
    idle(); a_we = 1; b_we = 1; a_ad = 4'd0; b_ad = 4'd1; a_wd = '1; b_wd = '1;
    step("R11 disabled");
    idle(); a_en = 1; a_ad = 4'd0; b_en = 1; b_ad = 4'd1; step("R11 unchanged");
    // R10: B write strobe in SDP build
    idle(); b_en = 1; b_we = 1; b_ad = 4'd2; b_wd = 32'h7777_7777; step("R10 B write");
    idle(); b_en = 1; b_ad = 4'd2; step("R10 B read");

    // random mix
    for (int n = 0; n < 600; n++) begin
      a_en = ($urandom % 4) != 0; a_we = $urandom % 2; a_ad = AW'($urandom);
      b_en = ($urandom % 4) != 0; b_we = $urandom % 2; b_ad = AW'($urandom);
      a_wd = $urandom; b_wd = $urandom;
      a_pi = (($urandom % 8) == 0) ? NB'($urandom) : '0;
      b_pi = (($urandom % 8) == 0) ? NB'($urandom) : '0;
      if (a_en && a_we && b_en && b_we && a_ad == b_ad) b_we = 0;
      step("R2 R7 R8 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule